// File: doc/BRIEF.md
# Capture/compare timer with selectable capture sources

A 16-bit timer/counter with three capture/compare channels. It sits behind a small register port. The count advances on ticks taken from one of three sources: a rising edge on an external clock pin, or either of two internal clock-enable strobes. The counter can be stopped, run in a periodic mode whose period is the channel 0 register, or run freely over the full 16-bit range. A wrap in either running mode raises the overflow flag.

Each channel works in one of two ways. In capture mode it latches the count on a chosen edge of its capture signal. In compare mode it signals a match when the count reaches its register and drives an output waveform. Each channel's capture signal comes from a four-way selector: two external inputs, constant low and constant high. Software can therefore force a capture by switching the selector from low to high. Channel 0 only sets the period and raises its flag. Channels 1 and 2 drive pins that can also feed the capture inputs of a second timer.

All flags clear when a 1 is written to them. Each flag is gated by its own enable, and the enabled flags are ORed onto a single interrupt line.

Top module: `cc_timer`

## Requirements
- R1: After reset the count, the flags, the channel outputs and the interrupt line are all 0, and every control register reads 0.
- R2: Register map, by address: 0 control, 1 count, 2 flags, 4+n channel n value, 8+n channel n control. Control bits are [1:0] mode (0 stop, 1 periodic, 2 free-running, 3 stop), [3:2] tick source, [4] counter clear (write-only strobe) and [5] overflow interrupt enable. In periodic mode each tick moves the count from k to k+1, or to 0 once k is at or above the channel 0 value. That wrap sets the overflow flag, flag bit 0.
- R3: In free-running mode the count goes from 0 to 0xFFFF and then to 0. The roll to 0 sets the overflow flag.
- R4: In stop mode ticks leave the count unchanged. A control write with bit 4 set forces the count to 0.
- R5: Tick source 0 counts one tick per rising edge of the external clock pin, however long the pin stays high. Source 1 and source 2 count one tick per clock cycle in which their strobe is high. Sources that are not selected have no effect.
- R6: Channel control bits are [0] capture mode, [2:1] edge (bit 1 rising, bit 2 falling, both for either edge), [4:3] source, [7:5] output mode, [8] output level and [9] interrupt enable. On a selected edge, capture mode stores the current count in the channel value and sets the channel flag, flags bit 1+n.
- R7: Capture source 0 is input A, 1 is input B, 2 is constant low and 3 is constant high. Changing the source from 2 to 3 produces a rising edge, so it captures.
- R8: A capture while the channel flag is still set also sets that channel's capture-overrun bit, flags bit 4+n.
- R9: In compare mode the channel flag is set on the tick that makes the count equal to the channel value.
- R10: Output modes on a match: 1 set, 5 reset, 4 toggle. Mode 0 drives the output level bit continuously. The outputs of channels 1 and 2 appear on out_o[0] and out_o[1].
- R11: Mode 3 sets on a match and mode 2 toggles on a match. Both clear the output on a periodic-mode wrap. When a match and a wrap fall on the same tick, the wrap clears first and the match then acts.
- R12: Writing 1 to a flag bit clears that bit. Writing 0 leaves the bit unchanged. A new event in the same cycle as the clear leaves the flag set.
- R13: irq_o is high whenever a set flag has its enable set: overflow with control bit 5, or a channel flag with that channel's bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_clk_i | input | 1 | External count clock pin, rising-edge detected |
| int_clk_a_i | input | 1 | Internal clock-enable strobe A |
| int_clk_b_i | input | 1 | Internal clock-enable strobe B |
| cap_a_i | input | 3 | Capture input A, one per channel |
| cap_b_i | input | 3 | Capture input B, one per channel |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data, combinational from addr_i |
| out_o | output | 2 | Compare outputs of channels 1 and 2 |
| irq_o | output | 1 | OR of the enabled flags |

## Verification
Two pairs of functions can land on the same cycle. The first pair is the periodic wrap and a compare match at value 0. The bench sets a zero compare value with a wrap-clearing output mode, then ticks through a wrap. It expects both outputs to read high afterwards, because the match acts after the clear. The second pair is a flag clear and a fresh event. The bench writes the overflow clear in the very cycle a period-0 tick wraps, then reads the flag. It must still be set, and the neighbouring channel 0 flag must be untouched by that write.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;
  typedef enum logic [1:0] {CNT_STOP = 2'd0, CNT_UP = 2'd1, CNT_CONT = 2'd2, CNT_HALT = 2'd3} cnt_mode_e;
  typedef enum logic [1:0] {SRC_EXT = 2'd0, SRC_INT_A = 2'd1, SRC_INT_B = 2'd2, SRC_NONE = 2'd3} tick_src_e;
  typedef enum logic [1:0] {IN_A = 2'd0, IN_B = 2'd1, IN_LOW = 2'd2, IN_HIGH = 2'd3} cap_in_e;
  typedef enum logic [2:0] {
    OM_LEVEL = 3'd0, OM_SET = 3'd1, OM_TOG_RST = 3'd2, OM_SET_RST = 3'd3,
    OM_TOGGLE = 3'd4, OM_RESET = 3'd5, OM_RSV6 = 3'd6, OM_RSV7 = 3'd7
  } out_mode_e;

  typedef struct packed {
    logic      irq_en;
    logic      out_lvl;
    out_mode_e omode;
    cap_in_e   in_sel;
    logic [1:0] edge_sel;
    logic      cap_en;
  } ch_ctl_t;

  localparam int CH_CTL_W = $bits(ch_ctl_t);
endpackage

// File: rtl/cc_tick_sel.sv
module cc_tick_sel
  import cc_timer_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  tick_src_e sel_i,
  input  logic      ext_i,
  input  logic      int_a_i,
  input  logic      int_b_i,
  output logic      tick_o
);
  logic ext_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ext_q <= 1'b0;
    else         ext_q <= ext_i;

  always_comb begin
    unique case (sel_i)
      SRC_EXT:   tick_o = ext_i & ~ext_q;
      SRC_INT_A: tick_o = int_a_i;
      SRC_INT_B: tick_o = int_b_i;
      default:   tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cc_counter.sv
module cc_counter
  import cc_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  cnt_mode_e    mode_i,
  input  logic         tick_i,
  input  logic         clr_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_nxt_o,
  output logic         adv_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign adv_o = tick_i & ~clr_i & ((mode_i == CNT_UP) | (mode_i == CNT_CONT));
  assign cnt_o = cnt_q;

  always_comb begin
    cnt_nxt_o = cnt_q;
    wrap_o    = 1'b0;
    if (adv_o) begin
      if (mode_i == CNT_UP && cnt_q >= period_i) begin
        cnt_nxt_o = '0;
        wrap_o    = 1'b1;
      end else begin
        cnt_nxt_o = cnt_q + 1'b1;
        wrap_o    = (mode_i == CNT_CONT) & (&cnt_q);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_nxt_o;

  assert_up_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_o && mode_i == CNT_UP && cnt_q >= period_i) |=> cnt_q == '0);
  assert_stop_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == CNT_STOP && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/cc_channel.sv
module cc_channel
  import cc_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_en_i,
  input  logic [1:0]   edge_sel_i,
  input  cap_in_e      in_sel_i,
  input  logic         cap_a_i,
  input  logic         cap_b_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cnt_nxt_i,
  input  logic         adv_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] ccr_o,
  output logic         cap_evt_o,
  output logic         match_o
);
  logic cap_src, cap_q, rise, fall;
  logic [W-1:0] ccr_q;

  always_comb begin
    unique case (in_sel_i)
      IN_A:    cap_src = cap_a_i;
      IN_B:    cap_src = cap_b_i;
      IN_LOW:  cap_src = 1'b0;
      default: cap_src = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cap_q <= 1'b0;
    else         cap_q <= cap_src;

  assign rise      = cap_src & ~cap_q;
  assign fall      = ~cap_src & cap_q;
  assign cap_evt_o = cap_en_i & ((edge_sel_i[0] & rise) | (edge_sel_i[1] & fall));
  assign match_o   = ~cap_en_i & adv_i & (cnt_nxt_i == ccr_q);
  assign ccr_o     = ccr_q;

  // capture wins over a software write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        ccr_q <= '0;
    else if (cap_evt_o) ccr_q <= cnt_i;
    else if (wr_i)      ccr_q <= wdata_i;

  assert_capture_value_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_o |=> ccr_q == $past(cnt_i));
endmodule

// File: rtl/cc_out_unit.sv
module cc_out_unit
  import cc_timer_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  out_mode_e omode_i,
  input  logic      lvl_i,
  input  logic      match_i,
  input  logic      wrap_i,
  output logic      out_o
);
  logic out_q, base, nxt;

  always_comb begin
    base = out_q;
    if (wrap_i && (omode_i == OM_SET_RST || omode_i == OM_TOG_RST)) base = 1'b0;
    nxt = base;
    if (omode_i == OM_LEVEL) nxt = lvl_i;
    else if (match_i) begin
      unique case (omode_i)
        OM_SET, OM_SET_RST:    nxt = 1'b1;
        OM_RESET:              nxt = 1'b0;
        OM_TOGGLE, OM_TOG_RST: nxt = ~base;
        default:               nxt = base;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= nxt;

  assign out_o = out_q;

  assert_set_on_match_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && omode_i == OM_SET) |=> out_q);
  assert_clear_on_wrap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && !match_i && omode_i == OM_SET_RST) |=> !out_q);
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cc_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_clk_i,
  input  logic              int_clk_a_i,
  input  logic              int_clk_b_i,
  input  logic [NUM_CH-1:0] cap_a_i,
  input  logic [NUM_CH-1:0] cap_b_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic [NUM_CH-2:0] out_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(2);
  localparam int A_CCR  = 4;
  localparam int A_CCTL = 8;
  localparam int FLG_W  = 2 * NUM_CH + 1;

  cnt_mode_e mode_q;
  tick_src_e src_q;
  logic      ovf_ie_q;
  ch_ctl_t   cctl_q [NUM_CH];

  logic wr_ctrl, wr_flags, clr;
  logic [NUM_CH-1:0] wr_ccr, wr_cctl, cap_evt, match, ch_evt, ch_ie;
  logic [NUM_CH-1:0] ch_flag, cov, ch_clr, cov_clr;
  logic ovf_flag, ovf_clr;
  logic tick, adv, wrap;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic [CNT_W-1:0] ccr [NUM_CH];

  assign wr_ctrl  = wr_en_i & (addr_i == A_CTRL);
  assign wr_flags = wr_en_i & (addr_i == A_FLAGS);
  assign clr      = wr_ctrl & wdata_i[4];
  assign ovf_clr  = wr_flags & wdata_i[0];
  assign ch_clr   = wr_flags ? wdata_i[NUM_CH:1] : '0;
  assign cov_clr  = wr_flags ? wdata_i[2*NUM_CH:NUM_CH+1] : '0;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      wr_ccr[i]  = wr_en_i & (addr_i == ADDR_W'(A_CCR + i));
      wr_cctl[i] = wr_en_i & (addr_i == ADDR_W'(A_CCTL + i));
      ch_ie[i]   = cctl_q[i].irq_en;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      mode_q   <= CNT_STOP;
      src_q    <= SRC_EXT;
      ovf_ie_q <= 1'b0;
    end else if (wr_ctrl) begin
      mode_q   <= cnt_mode_e'(wdata_i[1:0]);
      src_q    <= tick_src_e'(wdata_i[3:2]);
      ovf_ie_q <= wdata_i[5];
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) for (int i = 0; i < NUM_CH; i++) cctl_q[i] <= '0;
    else for (int i = 0; i < NUM_CH; i++)
      if (wr_cctl[i]) cctl_q[i] <= ch_ctl_t'(wdata_i[CH_CTL_W-1:0]);

  cc_tick_sel u_tick (
    .clk_i, .rst_ni, .sel_i(src_q), .ext_i(ext_clk_i),
    .int_a_i(int_clk_a_i), .int_b_i(int_clk_b_i), .tick_o(tick)
  );

  cc_counter #(.W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .mode_i(mode_q), .tick_i(tick), .clr_i(clr),
    .period_i(ccr[0]), .cnt_o(cnt), .cnt_nxt_o(cnt_nxt), .adv_o(adv), .wrap_o(wrap)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    cc_channel #(.W(CNT_W)) u_ch (
      .clk_i, .rst_ni,
      .cap_en_i(cctl_q[g].cap_en), .edge_sel_i(cctl_q[g].edge_sel), .in_sel_i(cctl_q[g].in_sel),
      .cap_a_i(cap_a_i[g]), .cap_b_i(cap_b_i[g]),
      .cnt_i(cnt), .cnt_nxt_i(cnt_nxt), .adv_i(adv),
      .wr_i(wr_ccr[g]), .wdata_i,
      .ccr_o(ccr[g]), .cap_evt_o(cap_evt[g]), .match_o(match[g])
    );
    assign ch_evt[g] = cap_evt[g] | match[g];

    assert_overrun_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cap_evt[g] && ch_flag[g]) |=> cov[g]);
  end

  // channel 0 has no pin: output units only for 1..NUM_CH-1
  for (genvar g = 1; g < NUM_CH; g++) begin : g_out
    cc_out_unit u_out (
      .clk_i, .rst_ni, .omode_i(cctl_q[g].omode), .lvl_i(cctl_q[g].out_lvl),
      .match_i(match[g]), .wrap_i(wrap), .out_o(out_o[g-1])
    );
  end

  // set has priority over write-1-clear
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      ovf_flag <= 1'b0;
      ch_flag  <= '0;
      cov      <= '0;
    end else begin
      ovf_flag <= wrap | (ovf_flag & ~ovf_clr);
      ch_flag  <= ch_evt | (ch_flag & ~ch_clr);
      cov      <= (cap_evt & ch_flag) | (cov & ~cov_clr);
    end

  assign irq_o = (ovf_flag & ovf_ie_q) | (|(ch_flag & ch_ie));

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTRL)  rdata_o[5:0] = {ovf_ie_q, 1'b0, src_q, mode_q};
    if (addr_i == A_CNT)   rdata_o = cnt;
    if (addr_i == A_FLAGS) rdata_o[FLG_W-1:0] = {cov, ch_flag, ovf_flag};
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr_i == ADDR_W'(A_CCR + i))  rdata_o = ccr[i];
      if (addr_i == ADDR_W'(A_CCTL + i)) rdata_o[CH_CTL_W-1:0] = cctl_q[i];
    end
  end

  assert_ovf_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> ovf_flag);
  assert_w1c_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_clr && !wrap) |=> !ovf_flag);
endmodule

// File: tb/cc_timer_test.sv
`timescale 1ns/1ps
module cc_timer_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ext_clk = 1'b0, int_a = 1'b0, int_b = 1'b0;
  logic [2:0]  cap_a = '0, cap_b = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  out;
  logic        irq;
  logic [15:0] d;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cc_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .ext_clk_i(ext_clk), .int_clk_a_i(int_a), .int_clk_b_i(int_b),
    .cap_a_i(cap_a), .cap_b_i(cap_b), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .out_o(out), .irq_o(irq)
  );

  localparam logic [3:0] A_CTRL = 4'd0, A_CNT = 4'd1, A_FLG = 4'd2;
  localparam logic [3:0] A_V0 = 4'd4, A_V1 = 4'd5, A_V2 = 4'd6, A_C1 = 4'd9, A_C2 = 4'd10;

  // {mode, period, ticks, expected count, expected overflow}
  localparam int NV = 7;
  localparam logic [42:0] VEC [NV] = '{
    {2'd1, 16'd5, 8'd3, 16'd3, 1'b0},
    {2'd1, 16'd5, 8'd5, 16'd5, 1'b0},
    {2'd1, 16'd5, 8'd6, 16'd0, 1'b1},
    {2'd1, 16'd5, 8'd8, 16'd2, 1'b1},
    {2'd1, 16'd0, 8'd3, 16'd0, 1'b1},
    {2'd2, 16'd5, 8'd4, 16'd4, 1'b0},
    {2'd0, 16'd5, 8'd4, 16'd0, 1'b0}
  };

  function automatic logic [15:0] ctl(input logic [1:0] m, input logic [1:0] s, input logic c, input logic ie);
    return {10'd0, ie, c, s, m};
  endfunction

  function automatic logic [15:0] cc(input logic cap, input logic [1:0] e, input logic [1:0] sel,
                                     input logic [2:0] om, input logic lvl, input logic ie);
    return {6'd0, ie, lvl, om, sel, e, cap};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] v);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic tick(input int n);
    @(negedge clk); int_a = 1'b1;
    repeat (n) @(negedge clk);
    int_a = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(A_CNT, d);  chk("R1 count", d, 16'd0);
    rd(A_FLG, d);  chk("R1 flags", d, 16'd0);
    rd(A_CTRL, d); chk("R1 control", d, 16'd0);
    chk("R1 outputs", {14'd0, out}, 16'd0);
    chk("R1 irq", {15'd0, irq}, 16'd0);

    // R2 / R4 table: periodic, free-running and stop behaviour
    for (int i = 0; i < NV; i++) begin
      wr(A_V0, VEC[i][40:25]);
      wr(A_CTRL, ctl(VEC[i][42:41], 2'd1, 1'b1, 1'b0));
      wr(A_FLG, 16'h007F);
      tick(int'(VEC[i][24:17]));
      rd(A_CNT, d); chk("R2 table count", d, VEC[i][16:1]);
      rd(A_FLG, d); chk("R2 table overflow", {15'd0, d[0]}, {15'd0, VEC[i][0]});
    end

    // R3 full-range roll
    wr(A_CTRL, ctl(2'd2, 2'd1, 1'b1, 1'b0));
    wr(A_FLG, 16'h007F);
    tick(65535);
    rd(A_CNT, d); chk("R3 top count", d, 16'hFFFF);
    rd(A_FLG, d); chk("R3 no overflow yet", {15'd0, d[0]}, 16'd0);
    tick(1);
    rd(A_CNT, d); chk("R3 roll count", d, 16'd0);
    rd(A_FLG, d); chk("R3 overflow", {15'd0, d[0]}, 16'd1);

    // R4 stop and clear
    tick(5);
    wr(A_CTRL, ctl(2'd0, 2'd1, 1'b0, 1'b0));
    tick(3);
    rd(A_CNT, d); chk("R4 stop holds", d, 16'd5);
    wr(A_CTRL, ctl(2'd0, 2'd1, 1'b1, 1'b0));
    rd(A_CNT, d); chk("R4 clear", d, 16'd0);

    // R5 tick source select
    wr(A_CTRL, ctl(2'd2, 2'd0, 1'b0, 1'b0));
    tick(3);
    rd(A_CNT, d); chk("R5 unselected strobe", d, 16'd0);
    @(negedge clk); ext_clk = 1'b1;
    repeat (3) @(negedge clk);
    ext_clk = 1'b0;
    @(negedge clk);
    rd(A_CNT, d); chk("R5 pin edge once", d, 16'd1);
    wr(A_CTRL, ctl(2'd2, 2'd2, 1'b0, 1'b0));
    @(negedge clk); int_b = 1'b1;
    repeat (2) @(negedge clk);
    int_b = 1'b0;
    rd(A_CNT, d); chk("R5 strobe B", d, 16'd3);

    // R6 capture on edges
    wr(A_CTRL, ctl(2'd2, 2'd1, 1'b1, 1'b0));
    wr(A_C1, cc(1'b1, 2'b01, 2'd0, 3'd0, 1'b0, 1'b0));
    tick(7);
    wr(A_FLG, 16'h007F);
    @(negedge clk); cap_a[1] = 1'b1;
    @(negedge clk);
    rd(A_V1, d); chk("R6 rising capture", d, 16'd7);
    rd(A_FLG, d); chk("R6 channel flag", {15'd0, d[2]}, 16'd1);
    chk("R8 no overrun on first", {15'd0, d[5]}, 16'd0);
    wr(A_FLG, 16'h007F);
    tick(2);
    @(negedge clk); cap_a[1] = 1'b0;
    @(negedge clk);
    rd(A_FLG, d); chk("R6 falling ignored", {15'd0, d[2]}, 16'd0);
    rd(A_V1, d); chk("R6 value kept", d, 16'd7);
    wr(A_C1, cc(1'b1, 2'b11, 2'd0, 3'd0, 1'b0, 1'b0));
    @(negedge clk); cap_a[1] = 1'b1;
    @(negedge clk);
    rd(A_V1, d); chk("R6 both-edge capture", d, 16'd9);

    // R8 overrun: flag left set
    tick(1);
    @(negedge clk); cap_a[1] = 1'b0;
    @(negedge clk);
    rd(A_V1, d); chk("R8 second capture", d, 16'd10);
    rd(A_FLG, d); chk("R8 overrun bit", {15'd0, d[5]}, 16'd1);

    // R7 source mux
    wr(A_FLG, 16'h007F);
    wr(A_C1, cc(1'b1, 2'b01, 2'd1, 3'd0, 1'b0, 1'b0));
    tick(2);
    @(negedge clk); cap_b[1] = 1'b1;
    @(negedge clk);
    rd(A_V1, d); chk("R7 input B capture", d, 16'd12);
    wr(A_FLG, 16'h007F);
    tick(3);
    wr(A_C1, cc(1'b1, 2'b01, 2'd2, 3'd0, 1'b0, 1'b0));
    rd(A_FLG, d); chk("R7 low source no capture", {15'd0, d[2]}, 16'd0);
    wr(A_C1, cc(1'b1, 2'b01, 2'd3, 3'd0, 1'b0, 1'b0));
    @(negedge clk);
    rd(A_V1, d); chk("R7 forced capture", d, 16'd15);
    rd(A_FLG, d); chk("R7 forced flag", {15'd0, d[2]}, 16'd1);

    // R9 / R10 compare
    wr(A_C1, cc(1'b0, 2'b00, 2'd0, 3'd1, 1'b0, 1'b0));
    wr(A_V1, 16'd3);
    wr(A_V0, 16'd5);
    wr(A_CTRL, ctl(2'd1, 2'd1, 1'b1, 1'b0));
    wr(A_FLG, 16'h007F);
    tick(2);
    chk("R10 before match", {15'd0, out[0]}, 16'd0);
    rd(A_FLG, d); chk("R9 no early flag", {15'd0, d[2]}, 16'd0);
    tick(1);
    chk("R10 set on match", {15'd0, out[0]}, 16'd1);
    rd(A_FLG, d); chk("R9 match flag", {15'd0, d[2]}, 16'd1);
    wr(A_C1, cc(1'b0, 2'b00, 2'd0, 3'd5, 1'b0, 1'b0));
    tick(6);
    chk("R10 reset on match", {15'd0, out[0]}, 16'd0);
    wr(A_C1, cc(1'b0, 2'b00, 2'd0, 3'd4, 1'b0, 1'b0));
    tick(6);
    chk("R10 toggle high", {15'd0, out[0]}, 16'd1);
    tick(6);
    chk("R10 toggle low", {15'd0, out[0]}, 16'd0);
    wr(A_C1, cc(1'b0, 2'b00, 2'd0, 3'd0, 1'b1, 1'b0));
    @(negedge clk);
    chk("R10 level mode", {15'd0, out[0]}, 16'd1);

    // R11 wrap clears, match after wrap
    wr(A_C1, cc(1'b0, 2'b00, 2'd0, 3'd3, 1'b0, 1'b0));
    tick(2);
    chk("R11 held before wrap", {15'd0, out[0]}, 16'd1);
    tick(1);
    chk("R11 cleared at wrap", {15'd0, out[0]}, 16'd0);
    tick(3);
    chk("R11 set at match", {15'd0, out[0]}, 16'd1);
    wr(A_V1, 16'd0);
    wr(A_C2, cc(1'b0, 2'b00, 2'd0, 3'd2, 1'b0, 1'b0));
    tick(2);
    chk("R11 ch2 low before wrap", {15'd0, out[1]}, 16'd0);
    tick(1);
    chk("R11 match and wrap same tick", {14'd0, out}, 16'd3);

    // R12 write-1-clear and same-cycle priority
    wr(A_V0, 16'd0);
    wr(A_CTRL, ctl(2'd1, 2'd1, 1'b1, 1'b0));
    wr(A_FLG, 16'h007F);
    rd(A_FLG, d); chk("R12 cleared", {15'd0, d[0]}, 16'd0);
    @(negedge clk); int_a = 1'b1; wr_en = 1'b1; addr = A_FLG; wdata = 16'h0001;
    @(negedge clk); int_a = 1'b0; wr_en = 1'b0;
    rd(A_FLG, d); chk("R12 event beats clear", {15'd0, d[0]}, 16'd1);
    wr(A_FLG, 16'h0001);
    rd(A_FLG, d); chk("R12 clear bit 0", {15'd0, d[0]}, 16'd0);
    chk("R12 other flag kept", {15'd0, d[1]}, 16'd1);

    // R13 interrupt gating
    wr(A_FLG, 16'h007F);
    wr(A_CTRL, ctl(2'd1, 2'd1, 1'b0, 1'b1));
    chk("R13 idle irq", {15'd0, irq}, 16'd0);
    tick(1);
    chk("R13 overflow irq", {15'd0, irq}, 16'd1);
    wr(A_FLG, 16'h007F);
    chk("R13 irq after clear", {15'd0, irq}, 16'd0);
    wr(A_CTRL, ctl(2'd1, 2'd1, 1'b0, 1'b0));
    tick(1);
    chk("R13 masked overflow", {15'd0, irq}, 16'd0);
    wr(A_C2, cc(1'b0, 2'b00, 2'd0, 3'd2, 1'b0, 1'b1));
    chk("R13 channel irq", {15'd0, irq}, 16'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule